// File: doc/BRIEF.md
# Read-to-Set Hardware Lock Register

This block is a small slave on a 16-bit local bus. It gives processor cores that share resources (a flash device or an I2C controller, for example) an atomic test-and-set lock in hardware. The lock comes with a companion 16-bit guarded register. Software uses the guarded register to record which resource each core has claimed.

A core reads the lock register. If the read returns zero, that core now owns the lock, because the read itself sets the lock once its bus cycle completes. The core may then update the guarded register. When it has finished, it releases the lock by writing zero to the lock register.

The hardware does not stop writes to the guarded register while the lock is held. Keeping to the protocol is software's job. The bus front end can present several ports in the same cycle. The block resolves accesses that arrive in the same cycle in ascending port order.

Top module: `hw_lock_reg`

## Requirements
- R1: After reset the lock is clear, the guarded register holds 0x0000, and every port's read data is 0x0000.
- R2: A read of the lock (chip select high, word offset LOCK_OFF = 0x38, that is byte 0x0070) returns the lock's value from before the read. The data is on the read bus one cycle after the strobe, as 0x0000 when the lock is clear and 0x8000 when it is set. The lock is set once that cycle completes.
- R3: While the lock is set, every further lock read returns 0x8000 and the lock stays set.
- R4: A write of exactly 0x0000 to the lock clears it, so the next lock read returns 0x0000.
- R5: A write of any nonzero value to the lock is ignored and leaves the lock in its previous state.
- R6: The guarded register (word offset GUARD_OFF = 0x39) is 16-bit read/write. Register bit k travels on bus lane 15-k in both directions, so a value written on the bus reads back unchanged one cycle after the read strobe. The lock's register bit 0 therefore appears on lane 15.
- R7: Writes to the guarded register take effect whether the lock is set or clear.
- R8: When more than one port reads the lock in the same cycle, only the lowest-numbered port can receive 0x0000. Every higher port receives 0x8000.
- R9: A read without chip select, or at an offset that is neither LOCK_OFF nor GUARD_OFF, returns 0x0000. Such an access, read or write, changes neither the lock nor the guarded register.
- R10: Accesses in the same cycle apply in ascending port order. A zero write from a lower port is seen by a lock read from a higher port. For the guarded register, reads return the value from before the cycle, and when several ports write it the highest port's data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | NP | Per-port chip select for this register region |
| bus_off | input | NP x OFFW | Per-port word offset |
| bus_rd | input | NP | Per-port read strobe (one cycle) |
| bus_wr | input | NP | Per-port write strobe (one cycle) |
| bus_wdata | input | NP x 16 | Per-port write data, bus lane order |
| bus_rdata | output | NP x 16 | Per-port read data, one cycle after the read strobe, zero otherwise |

## Verification
The lock is driven through these sequences:
- a first read after reset;
- repeated reads while the lock is held;
- zero writes;
- a sweep of walking-one nonzero writes, made with the lock both clear and set.

Together these separate a read-to-set lock from a plain register and from a lock that clears on any write. The guarded register gets walking-one patterns written in bus lane order, with the lock in each state, which exposes a lane-order error or a write that the lock gates.

Same-cycle pairs are also applied:
- read against read;
- zero write against read, with the ports in both orders;
- write against write on the guarded register.

These distinguish port-ordered resolution from a race. A full sweep of offsets, with chip select both high and low, checks that misses neither return data nor disturb the lock.

// File: rtl/sem_pkg.sv
package sem_pkg;
    // decoded intent of one port in one cycle
    typedef struct packed {
        logic lock_rd;
        logic lock_clr;
        logic guard_rd;
        logic guard_wr;
    } sem_hit_t;
endpackage

// File: rtl/sem_lane_rev.sv
module sem_lane_rev #(
    parameter int W = 16
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // register bit k <-> bus lane W-1-k
    for (genvar k = 0; k < W; k++) begin : g_lane
        assign dout[k] = din[W-1-k];
    end
endmodule

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_pkg::*;
#(
    parameter int          OFFW      = 8,
    parameter int          DW        = 16,
    parameter logic [OFFW-1:0] LOCK_OFF  = 8'h38,
    parameter logic [OFFW-1:0] GUARD_OFF = 8'h39
) (
    input  logic            cs,
    input  logic [OFFW-1:0] off,
    input  logic            rd,
    input  logic            wr,
    input  logic [DW-1:0]   wdata,
    output sem_hit_t        hit
);
    logic at_lock;
    logic at_guard;

    always_comb begin
        at_lock      = cs && (off == LOCK_OFF);
        at_guard     = cs && (off == GUARD_OFF);
        hit.lock_rd  = at_lock && rd;
        hit.lock_clr = at_lock && wr && (wdata == '0);
        hit.guard_rd = at_guard && rd;
        hit.guard_wr = at_guard && wr;
    end
endmodule

// File: rtl/hw_lock_reg.sv
module hw_lock_reg
    import sem_pkg::*;
#(
    parameter int              NP        = 2,
    parameter int              OFFW      = 8,
    parameter int              DW        = 16,
    parameter logic [OFFW-1:0] LOCK_OFF  = 8'h38,
    parameter logic [OFFW-1:0] GUARD_OFF = 8'h39
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NP-1:0]            bus_cs,
    input  logic [NP-1:0][OFFW-1:0]  bus_off,
    input  logic [NP-1:0]            bus_rd,
    input  logic [NP-1:0]            bus_wr,
    input  logic [NP-1:0][DW-1:0]    bus_wdata,
    output logic [NP-1:0][DW-1:0]    bus_rdata
);
    localparam logic [DW-1:0] LOCK_SET_REG = DW'(1);

    typedef struct packed {
        logic                  lock;
        logic [DW-1:0]         guard;   // register bit order
        logic [NP-1:0][DW-1:0] rdata;   // register bit order
        logic [NP-1:0]         grant;   // port that won the lock this cycle
    } state_t;

    state_t st_d, st_q;

    sem_hit_t [NP-1:0]      hit;
    logic [NP-1:0][DW-1:0]  wreg;

    for (genvar p = 0; p < NP; p++) begin : g_port
        sem_lane_rev #(.W(DW)) u_wr_rev (
            .din  (bus_wdata[p]),
            .dout (wreg[p])
        );
        sem_port_decode #(
            .OFFW(OFFW), .DW(DW), .LOCK_OFF(LOCK_OFF), .GUARD_OFF(GUARD_OFF)
        ) u_dec (
            .cs    (bus_cs[p]),
            .off   (bus_off[p]),
            .rd    (bus_rd[p]),
            .wr    (bus_wr[p]),
            .wdata (bus_wdata[p]),
            .hit   (hit[p])
        );
        sem_lane_rev #(.W(DW)) u_rd_rev (
            .din  (st_q.rdata[p]),
            .dout (bus_rdata[p])
        );

        // R9: a cycle with no decoded read leaves zero on the read bus
        p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !(hit[p].lock_rd || hit[p].guard_rd) |=> bus_rdata[p] == '0);
    end

    always_comb begin
        logic lk;
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.grant = '0;
        lk         = st_q.lock;
        // ports resolved in ascending order
        for (int p = 0; p < NP; p++) begin
            if (hit[p].lock_rd) begin
                st_d.rdata[p] = lk ? LOCK_SET_REG : '0;
                st_d.grant[p] = !lk;
                lk            = 1'b1;
            end
            if (hit[p].lock_clr) begin
                lk = 1'b0;
            end
            if (hit[p].guard_rd) begin
                st_d.rdata[p] = st_q.guard;
            end
            if (hit[p].guard_wr) begin
                st_d.guard = wreg[p];
            end
        end
        st_d.lock = lk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic any_lock_rd, any_lock_clr, any_guard_wr;
    always_comb begin
        any_lock_rd  = 1'b0;
        any_lock_clr = 1'b0;
        any_guard_wr = 1'b0;
        for (int p = 0; p < NP; p++) begin
            any_lock_rd  |= hit[p].lock_rd;
            any_lock_clr |= hit[p].lock_clr;
            any_guard_wr |= hit[p].guard_wr;
        end
    end

    // R2/R3: a read with no release in the same cycle leaves the lock set
    p_read_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_lock_rd && !any_lock_clr |=> st_q.lock);
    // R4: a zero write alone releases the lock
    p_zero_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_lock_clr && !any_lock_rd |=> !st_q.lock);
    // R5/R9: without a lock read or a zero write the lock holds its value
    p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !any_lock_rd && !any_lock_clr |=> $stable(st_q.lock));
    // R8: at most one port is granted per cycle
    p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.grant));
    // R6/R9: the guarded register changes only on a decoded write
    p_guard_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !any_guard_wr |=> $stable(st_q.guard));
endmodule

// File: tb/hw_lock_reg_tb.sv
module hw_lock_reg_tb;
    localparam int NP = 2;
    localparam logic [7:0] LOCK  = 8'h38;
    localparam logic [7:0] GUARD = 8'h39;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NP-1:0]        bus_cs = '0;
    logic [NP-1:0][7:0]   bus_off = '0;
    logic [NP-1:0]        bus_rd = '0;
    logic [NP-1:0]        bus_wr = '0;
    logic [NP-1:0][15:0]  bus_wdata = '0;
    logic [NP-1:0][15:0]  bus_rdata;

    int checks = 0;
    int fails  = 0;

    // bench model, bus lane order
    logic        m_lock  = 1'b0;
    logic [15:0] m_guard = 16'h0000;

    always #2.5 clk = ~clk;   // 200 MHz

    hw_lock_reg #(.NP(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_off(bus_off),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input int port,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s port %0d: got %h expected %h", req, port, act, exp);
        end
    endtask

    // one bus cycle on both ports; expected data computed from the requirements
    task automatic cyc(input string req,
                       input logic c0, input logic [7:0] o0, input logic r0,
                       input logic w0, input logic [15:0] d0,
                       input logic c1, input logic [7:0] o1, input logic r1,
                       input logic w1, input logic [15:0] d1);
        logic [1:0][15:0] exp;
        logic [15:0]      g_old;
        logic             cs [2];
        logic [7:0]       of [2];
        logic             rd [2];
        logic             wr [2];
        logic [15:0]      wd [2];
        cs[0] = c0; of[0] = o0; rd[0] = r0; wr[0] = w0; wd[0] = d0;
        cs[1] = c1; of[1] = o1; rd[1] = r1; wr[1] = w1; wd[1] = d1;
        bus_cs = {c1, c0}; bus_off = {o1, o0}; bus_rd = {r1, r0};
        bus_wr = {w1, w0}; bus_wdata = {d1, d0};
        exp   = '0;
        g_old = m_guard;
        for (int p = 0; p < 2; p++) begin
            if (cs[p] && of[p] == LOCK && rd[p]) begin
                exp[p] = m_lock ? 16'h8000 : 16'h0000;
                m_lock = 1'b1;
            end
            if (cs[p] && of[p] == LOCK && wr[p] && wd[p] == 16'h0000) m_lock = 1'b0;
            if (cs[p] && of[p] == GUARD && rd[p]) exp[p] = g_old;
            if (cs[p] && of[p] == GUARD && wr[p]) m_guard = wd[p];
        end
        @(posedge clk);
        @(negedge clk);
        bus_cs = '0; bus_rd = '0; bus_wr = '0;
        check(req, 0, bus_rdata[0], exp[0]);
        check(req, 1, bus_rdata[1], exp[1]);
    endtask

    task automatic rd1(input string req, input logic [7:0] o);
        cyc(req, 1, o, 1, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wr1(input string req, input logic [7:0] o, input logic [15:0] d);
        cyc(req, 1, o, 0, 1, d, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle read bus, then lock and guarded register read as clear
        check("R1", 0, bus_rdata[0], 16'h0000);
        check("R1", 1, bus_rdata[1], 16'h0000);
        rd1("R1", GUARD);
        rd1("R2", LOCK);                 // first read returns 0 and sets
        check("R2", 0, bus_rdata[0], 16'h0000);
        for (int i = 0; i < 3; i++) rd1("R3", LOCK);
        // R5: nonzero writes with lock set, then with lock clear
        for (int k = 0; k < 16; k++) begin
            wr1("R5", LOCK, 16'(1) << k);
            rd1("R5", LOCK);
        end
        for (int k = 0; k < 16; k++) begin
            wr1("R4", LOCK, 16'h0000);
            wr1("R5", LOCK, 16'(1) << k);
            rd1("R5", LOCK);             // still clear: returns 0
        end
        wr1("R4", LOCK, 16'h0000);
        rd1("R4", LOCK);
        // R6/R7: walking ones, lock set (now) and lock clear
        for (int k = 0; k < 16; k++) begin
            wr1("R7", GUARD, 16'(1) << k);
            rd1("R6", GUARD);
        end
        wr1("R4", LOCK, 16'h0000);
        for (int k = 0; k < 16; k++) begin
            wr1("R6", GUARD, ~(16'(1) << k));
            rd1("R6", GUARD);
        end
        // R8: simultaneous lock reads
        cyc("R8", 1, LOCK, 1, 0, 0, 1, LOCK, 1, 0, 0);
        check("R8", 1, bus_rdata[1], 16'h8000);
        cyc("R8", 1, LOCK, 1, 0, 0, 1, LOCK, 1, 0, 0);
        // R10: port0 release seen by port1 read
        cyc("R10", 1, LOCK, 0, 1, 0, 1, LOCK, 1, 0, 0);
        check("R10", 1, bus_rdata[1], 16'h0000);
        // R10: port0 read then port1 release leaves lock clear
        cyc("R10", 1, LOCK, 1, 0, 0, 1, LOCK, 0, 1, 0);
        rd1("R10", LOCK);
        // R10: guarded read sees old value, port1 write wins
        cyc("R10", 1, GUARD, 1, 1, 16'h1234, 1, GUARD, 0, 1, 16'hBEEF);
        rd1("R10", GUARD);
        // R9: offset sweep with lock set
        rd1("R9", LOCK);
        for (int o = 0; o < 256; o++) begin
            cyc("R9", 0, 8'(o), 1, 1, 0, 0, 8'(o), 1, 1, 16'h0000);
            if (8'(o) != LOCK && 8'(o) != GUARD)
                cyc("R9", 1, 8'(o), 1, 1, 0, 1, 8'(o), 1, 1, 16'h0000);
        end
        rd1("R9", LOCK);
        rd1("R9", GUARD);
        // R9: no chip select at lock offset with lock clear keeps it clear
        wr1("R4", LOCK, 16'h0000);
        cyc("R9", 0, LOCK, 1, 0, 0, 0, LOCK, 1, 0, 0);
        rd1("R9", LOCK);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule